// File: doc/BRIEF.md
# Isochronous Cycle Timer and Monitor

This block keeps the bus time of a node on a high-speed serial bus. It holds a 32-bit time value split into three mixed-radix fields: a sub-cycle offset that counts periods of a 24.576 MHz time base, a cycle count that marks 125 µs isochronous cycles, and a seconds count. The time base reaches the block as a one-cycle `tick` strobe in the system clock domain. A node that takes its cycle timing from an external 8 kHz source can instead step the cycle count from that source's rising edges. The source is asynchronous to the clock and is synchronized inside the block.

Each new cycle produces a one-clock `cyc_out` pulse. On the cycle master that pulse also asks the transmit path to send a cycle-start packet. On any other node, a cycle start received from the bus reloads the whole time value, which keeps the node locked to the master. A monitor tracks three sticky events: a cycle start seen, a cycle start missing, and the end of the isochronous period. Each event has its own mask bit, and together they drive an active-low interrupt. The time value is a plain output that the host register file reads at its own address.

Top module: `isotime_core`

## Requirements
- R1: `ctime` holds the offset in bits [11:0], the cycle count in bits [24:12] and the seconds in bits [31:25]. After reset `ctime` is 0, `flags` is 0, `irq_n` is 1, and `cyc_out` and `cs_tx_req` are 0.
- R2: With `cfg_enable`=1 and `cfg_src_ext`=0, each clock with `tick`=1 advances the offset modulo OFFS_MOD. The offset wrap increments the cycle count modulo CYC_MOD, which carries into the seconds modulo 128. In the clock where the new cycle value appears, `cyc_out` is 1 for exactly one clock and the offset reads 0. Clocks with `tick`=0 change nothing.
- R3: With `cfg_enable`=1 and `cfg_src_ext`=1, each rising edge of `ext_cyc`, after a SYNC_STAGES-flop synchronizer, clears the offset, increments the cycle count (with carry) and pulses `cyc_out`. Ticks still advance the offset, but an offset wrap then neither carries nor pulses `cyc_out`.
- R4: With `cfg_enable`=0, neither ticks nor `ext_cyc` edges change `ctime`.
- R5: When `rx_cs_valid`=1 and `cfg_master`=0, `ctime` equals `rx_cs_time` on the next clock. This load takes priority over counting and works whatever `cfg_enable` is. When `cfg_master`=1, `rx_cs_valid` is ignored.
- R6: `cs_tx_req` pulses in the same clock as `cyc_out` when `cfg_master`=1, and stays 0 when `cfg_master`=0.
- R7: `flags` bit 0 (cycle started) is set by a `cs_tx_req` pulse or by an accepted received cycle start (R5).
- R8: `flags` bit 1 (cycle lost) works only when `cfg_master`=0. A `cyc_out` pulse opens a window. If no `rx_cs_valid` arrives, the flag is set by the (LOST_WIN+1)-th clock edge after the edge that raised `cyc_out`. A received start inside the window closes it without setting the flag.
- R9: `flags` bit 2 (cycle done) is set by an `iso_gap` pulse only when a cycle start (R7) has occurred since the last cycle-done event. An `iso_gap` pulse with no such start is ignored.
- R10: Flags are sticky. A 1 in bit i of `flag_clr` clears flag i on the next clock, and a set event in the same clock wins over the clear.
- R11: `irq_n` is 0 exactly when some flag bit i is 1 and `flag_mask` bit i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per 24.576 MHz time-base period |
| ext_cyc | input | 1 | External 8 kHz cycle source, asynchronous |
| cfg_enable | input | 1 | Counting enable |
| cfg_src_ext | input | 1 | 1: cycle steps come from `ext_cyc` edges |
| cfg_master | input | 1 | Node is cycle master |
| rx_cs_valid | input | 1 | A cycle-start packet was received this clock |
| rx_cs_time | input | 32 | Time value carried by that packet |
| iso_gap | input | 1 | End-of-isochronous-period strobe from the bus side |
| flag_clr | input | 3 | Write-1-to-clear strobes for the flags |
| flag_mask | input | 3 | Interrupt enable per flag |
| ctime | output | 32 | Current time value (host readable) |
| cyc_out | output | 1 | One-clock pulse at each new cycle |
| cs_tx_req | output | 1 | Request to send a cycle-start packet |
| flags | output | 3 | Sticky flags: started, lost, done |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with OFFS_MOD=6, CYC_MOD=5, LOST_WIN=10 and two synchronizer stages, and keeps the field widths at their defaults so the bit positions are the ones the host sees. With these moduli, a full pass through every offset, cycle and second, including the seconds wrap from 127 to 0, takes only 3840 ticks. The bench therefore sweeps the entire time space and compares every step against arithmetic on the tick count. The short lost window lets it probe the exact clock on which the lost flag rises, and the small cycle modulus lets a few external edges carry into the seconds.

// File: rtl/isotime_pkg.sv
package isotime_pkg;
   // Positions of the sticky event flags; the host decodes them.
   localparam int unsigned FLG_START = 0;
   localparam int unsigned FLG_LOST  = 1;
   localparam int unsigned FLG_DONE  = 2;
   localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/isotime_edge.sv
// Synchronizes an asynchronous level and reports its rising edges.
// Reset fills the chain with ones so a source tied high gives no false edge.
module isotime_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("isotime_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/isotime_counter.sv
// Mixed-radix time counter: offset (mod OFFS_MOD), cycle (mod CYC_MOD), seconds.
module isotime_counter #(
   parameter int unsigned OFFS_W   = 12,
   parameter int unsigned CYC_W    = 13,
   parameter int unsigned SEC_W    = 7,
   parameter int unsigned OFFS_MOD = 3072,
   parameter int unsigned CYC_MOD  = 8000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          ext_rise,
   input  logic                          enable,
   input  logic                          src_ext,
   input  logic                          master,
   input  logic                          load,
   input  logic [OFFS_W+CYC_W+SEC_W-1:0] load_val,
   output logic [OFFS_W+CYC_W+SEC_W-1:0] ctime,
   output logic                          cyc_out,
   output logic                          tx_req
);
   localparam int unsigned CYC_LSB = OFFS_W;
   localparam int unsigned SEC_LSB = OFFS_W + CYC_W;
   localparam int unsigned TIME_W  = OFFS_W + CYC_W + SEC_W;

   logic [OFFS_W-1:0] off_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [SEC_W-1:0]  sec_q;
   logic              off_last;
   logic              cyc_last;
   logic              step;
   logic              off_adv;

   // A modulus equal to the field range wraps by plain overflow.
   generate
      if (OFFS_MOD == (1 << OFFS_W)) begin : g_off_full
         assign off_last = &off_q;
      end else begin : g_off_cmp
         assign off_last = (off_q == OFFS_W'(OFFS_MOD - 1));
      end
      if (CYC_MOD == (1 << CYC_W)) begin : g_cyc_full
         assign cyc_last = &cyc_q;
      end else begin : g_cyc_cmp
         assign cyc_last = (cyc_q == CYC_W'(CYC_MOD - 1));
      end
   endgenerate

   // step: a new cycle begins; off_adv: offset moves without a new cycle.
   always_comb begin
      step    = 1'b0;
      off_adv = 1'b0;
      if (!load && enable) begin
         if (src_ext) begin
            step    = ext_rise;
            off_adv = tick & ~ext_rise;
         end else begin
            step    = tick & off_last;
            off_adv = tick & ~off_last;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         cyc_q   <= '0;
         sec_q   <= '0;
         cyc_out <= 1'b0;
         tx_req  <= 1'b0;
      end else begin
         if (load) begin
            off_q <= load_val[CYC_LSB-1:0];
            cyc_q <= load_val[SEC_LSB-1:CYC_LSB];
            sec_q <= load_val[TIME_W-1:SEC_LSB];
         end else if (step) begin
            off_q <= '0;
            if (cyc_last) begin
               cyc_q <= '0;
               sec_q <= sec_q + 1'b1;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
         end else if (off_adv) begin
            off_q <= off_last ? '0 : off_q + 1'b1;
         end
         cyc_out <= step;
         tx_req  <= step & master;
      end
   end

   assign ctime = {sec_q, cyc_q, off_q};
endmodule

// File: rtl/isotime_monitor.sv
// Sticky event flags, lost-start window and masked interrupt.
module isotime_monitor
   import isotime_pkg::*;
#(
   parameter int unsigned LOST_WIN = 4096
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cyc_out,
   input  logic                 tx_req,
   input  logic                 rx_start,
   input  logic                 master,
   input  logic                 iso_gap,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   input  logic [NUM_FLAGS-1:0] flag_mask,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 irq_n
);
   localparam int unsigned CNT_W = $clog2(LOST_WIN + 1);

   logic                 armed_q;
   logic [CNT_W-1:0]     win_q;
   logic                 in_cyc_q;
   logic                 start_evt;
   logic                 lost_hit;
   logic                 done_hit;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] flags_q;

   assign start_evt = tx_req | rx_start;
   assign lost_hit  = armed_q & ~rx_start & (win_q == CNT_W'(LOST_WIN - 1));
   assign done_hit  = iso_gap & in_cyc_q;

   always_comb begin
      set_vec            = '0;
      set_vec[FLG_START] = start_evt;
      set_vec[FLG_LOST]  = lost_hit;
      set_vec[FLG_DONE]  = done_hit;
   end

   // Window for the expected received start after a local cycle boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         win_q   <= '0;
      end else if (rx_start) begin
         armed_q <= 1'b0;
         win_q   <= '0;
      end else if (cyc_out && !master) begin
         armed_q <= 1'b1;
         win_q   <= '0;
      end else if (armed_q) begin
         if (lost_hit) begin
            armed_q <= 1'b0;
         end
         win_q <= win_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cyc_q <= 1'b0;
         flags_q  <= '0;
      end else begin
         if (start_evt) begin
            in_cyc_q <= 1'b1;
         end else if (done_hit) begin
            in_cyc_q <= 1'b0;
         end
         flags_q <= (flags_q & ~flag_clr) | set_vec;
      end
   end

   assign flags = flags_q;
   assign irq_n = ~|(flags_q & flag_mask);
endmodule

// File: rtl/isotime_core.sv
// Cycle timer and cycle monitor top level.
module isotime_core
   import isotime_pkg::*;
#(
   parameter int unsigned OFFS_W      = 12,
   parameter int unsigned CYC_W       = 13,
   parameter int unsigned SEC_W       = 7,
   parameter int unsigned OFFS_MOD    = 3072,
   parameter int unsigned CYC_MOD     = 8000,
   parameter int unsigned LOST_WIN    = 4096,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          ext_cyc,
   input  logic                          cfg_enable,
   input  logic                          cfg_src_ext,
   input  logic                          cfg_master,
   input  logic                          rx_cs_valid,
   input  logic [OFFS_W+CYC_W+SEC_W-1:0] rx_cs_time,
   input  logic                          iso_gap,
   input  logic [NUM_FLAGS-1:0]          flag_clr,
   input  logic [NUM_FLAGS-1:0]          flag_mask,
   output logic [OFFS_W+CYC_W+SEC_W-1:0] ctime,
   output logic                          cyc_out,
   output logic                          cs_tx_req,
   output logic [NUM_FLAGS-1:0]          flags,
   output logic                          irq_n
);
   localparam int unsigned TIME_W = OFFS_W + CYC_W + SEC_W;

   generate
      if (OFFS_MOD < 2 || OFFS_MOD > (1 << OFFS_W)) begin : g_bad_offs
         $error("isotime_core: OFFS_MOD does not fit OFFS_W");
      end
      if (CYC_MOD < 2 || CYC_MOD > (1 << CYC_W)) begin : g_bad_cyc
         $error("isotime_core: CYC_MOD does not fit CYC_W");
      end
      if (SEC_W < 1 || TIME_W > 64) begin : g_bad_time
         $error("isotime_core: time field widths out of range");
      end
      if (LOST_WIN < 1) begin : g_bad_win
         $error("isotime_core: LOST_WIN must be at least 1");
      end
   endgenerate

   logic ext_rise;
   logic rx_accept;
   logic tx_req;

   assign rx_accept = rx_cs_valid & ~cfg_master;

   isotime_edge #(
      .STAGES(SYNC_STAGES)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_cyc),
      .rise    (ext_rise)
   );

   isotime_counter #(
      .OFFS_W  (OFFS_W),
      .CYC_W   (CYC_W),
      .SEC_W   (SEC_W),
      .OFFS_MOD(OFFS_MOD),
      .CYC_MOD (CYC_MOD)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ext_rise(ext_rise),
      .enable  (cfg_enable),
      .src_ext (cfg_src_ext),
      .master  (cfg_master),
      .load    (rx_accept),
      .load_val(rx_cs_time),
      .ctime   (ctime),
      .cyc_out (cyc_out),
      .tx_req  (tx_req)
   );

   isotime_monitor #(
      .LOST_WIN(LOST_WIN)
   ) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_out  (cyc_out),
      .tx_req   (tx_req),
      .rx_start (rx_accept),
      .master   (cfg_master),
      .iso_gap  (iso_gap),
      .flag_clr (flag_clr),
      .flag_mask(flag_mask),
      .flags    (flags),
      .irq_n    (irq_n)
   );

   assign cs_tx_req = tx_req;
endmodule

// File: rtl/isotime_core_chk.sv
module isotime_core_chk #(
   parameter int unsigned TIME_W = 32,
   parameter int unsigned OFFS_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic              cfg_master,
   input logic              rx_cs_valid,
   input logic [TIME_W-1:0] rx_cs_time,
   input logic [2:0]        flag_clr,
   input logic [TIME_W-1:0] ctime,
   input logic              cyc_out,
   input logic              cs_tx_req,
   input logic [2:0]        flags
);
   // R4
   halt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_enable && !(rx_cs_valid && !cfg_master)) |=> $stable(ctime));

   // R5
   resync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cs_valid && !cfg_master) |=> (ctime == $past(rx_cs_time)));

   // R6
   txreq_cycout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_tx_req |-> cyc_out);

   // R2
   cycout_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_out |-> (ctime[OFFS_W-1:0] == '0));

   // R10
   start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !flag_clr[0]) |=> flags[0]);

   // R10
   lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[1] && !flag_clr[1]) |=> flags[1]);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[2] && !flag_clr[2]) |=> flags[2]);
endmodule

bind isotime_core isotime_core_chk #(
   .TIME_W(TIME_W),
   .OFFS_W(OFFS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .cfg_master (cfg_master),
   .rx_cs_valid(rx_cs_valid),
   .rx_cs_time (rx_cs_time),
   .flag_clr   (flag_clr),
   .ctime      (ctime),
   .cyc_out    (cyc_out),
   .cs_tx_req  (cs_tx_req),
   .flags      (flags)
);

// File: tb/isotime_core_test.sv
module isotime_core_test;
   localparam int OM = 6;
   localparam int CM = 5;
   localparam int LW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ext_cyc = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        cfg_src_ext = 1'b0;
   logic        cfg_master = 1'b0;
   logic        rx_cs_valid = 1'b0;
   logic [31:0] rx_cs_time = '0;
   logic        iso_gap = 1'b0;
   logic [2:0]  flag_clr = '0;
   logic [2:0]  flag_mask = '0;
   logic [31:0] ctime;
   logic        cyc_out;
   logic        cs_tx_req;
   logic [2:0]  flags;
   logic        irq_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   int es = 0, ec = 0, eo = 0;

   always #10 clk = ~clk;

   isotime_core #(.OFFS_MOD(OM), .CYC_MOD(CM), .LOST_WIN(LW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ext_cyc(ext_cyc),
      .cfg_enable(cfg_enable), .cfg_src_ext(cfg_src_ext), .cfg_master(cfg_master),
      .rx_cs_valid(rx_cs_valid), .rx_cs_time(rx_cs_time), .iso_gap(iso_gap),
      .flag_clr(flag_clr), .flag_mask(flag_mask), .ctime(ctime), .cyc_out(cyc_out),
      .cs_tx_req(cs_tx_req), .flags(flags), .irq_n(irq_n));

   function automatic logic [31:0] pack(input int s, input int c, input int o);
      return {7'(s), 13'(c), 12'(o)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic bump();
      eo = 0;
      ec = ec + 1;
      if (ec == CM) begin
         ec = 0;
         es = (es + 1) % 128;
      end
   endtask

   task automatic ext_pulse();
      ext_cyc = 1'b1;
      wait_n(4);
      ext_cyc = 1'b0;
      wait_n(4);
   endtask

   task automatic rx_load(input logic [31:0] t);
      rx_cs_time  = t;
      rx_cs_valid = 1'b1;
      wait_n(1);
      rx_cs_valid = 1'b0;
   endtask

   task automatic clear_flags();
      flag_clr = 3'b111;
      wait_n(1);
      flag_clr = 3'b000;
   endtask

   task automatic gap_pulse();
      iso_gap = 1'b1;
      wait_n(1);
      iso_gap = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      chk("R1 reset ctime", ctime, 32'h0);
      chk("R1 reset flags", 32'(flags), 32'h0);
      chk("R1 reset irq_n", 32'(irq_n), 32'h1);
      chk("R1 reset cyc_out", 32'(cyc_out), 32'h0);

      // R2 / R6: full sweep of the time space, master mode
      cfg_master = 1'b1;
      cfg_enable = 1'b1;
      tick = 1'b1;
      for (int n = 1; n <= OM * CM * 128; n++) begin
         wait_n(1);
         chk("R2 sweep ctime", ctime, pack((n / (OM * CM)) % 128, (n / OM) % CM, n % OM));
         chk("R2 sweep cyc_out", 32'(cyc_out), 32'((n % OM) == 0));
         chk("R6 sweep cs_tx_req", 32'(cs_tx_req), 32'((n % OM) == 0));
      end
      for (int n = 1; n <= 7; n++) wait_n(1);
      tick = 1'b0;
      es = 0; ec = 1; eo = 1;
      wait_n(3);
      chk("R2 no tick holds", ctime, pack(es, ec, eo));

      // R4: halted counter ignores ticks
      cfg_enable = 1'b0;
      tick = 1'b1;
      wait_n(6);
      tick = 1'b0;
      wait_n(1);
      chk("R4 halt ticks", ctime, pack(es, ec, eo));

      chk("R7 started by tx", 32'(flags[0]), 32'h1);
      #1;
      chk("R11 masked off", 32'(irq_n), 32'h1);
      flag_mask = 3'b001;
      #1;
      chk("R11 masked on", 32'(irq_n), 32'h0);
      flag_mask = 3'b000;
      wait_n(1);
      clear_flags();
      chk("R10 clear", 32'(flags), 32'h0);

      // R3: external cycle source, carry into seconds
      cfg_enable = 1'b1;
      cfg_src_ext = 1'b1;
      for (int p = 0; p < 7; p++) begin
         ext_pulse();
         bump();
         chk("R3 ext edge", ctime, pack(es, ec, eo));
      end
      tick = 1'b1;
      for (int n = 0; n < 8; n++) begin
         wait_n(1);
         chk("R3 ext wrap no cyc_out", 32'(cyc_out), 32'h0);
      end
      tick = 1'b0;
      eo = 8 % OM;
      wait_n(1);
      chk("R3 ext ticks offset", ctime, pack(es, ec, eo));
      ext_pulse();
      bump();
      chk("R3 ext edge clears offset", ctime, pack(es, ec, eo));
      cfg_enable = 1'b0;
      ext_pulse();
      chk("R4 halt ext edge", ctime, pack(es, ec, eo));
      cfg_enable = 1'b1;
      cfg_src_ext = 1'b0;

      // R5 / R7: resync from received cycle start
      cfg_master = 1'b0;
      clear_flags();
      rx_load(pack(93, 4, 3));
      chk("R5 resync load", ctime, pack(93, 4, 3));
      chk("R7 started by rx", 32'(flags[0]), 32'h1);
      clear_flags();
      cfg_master = 1'b1;
      rx_load(pack(10, 1, 1));
      wait_n(1);
      chk("R5 master ignores rx", ctime, pack(93, 4, 3));
      chk("R7 master rx no flag", 32'(flags), 32'h0);
      cfg_master = 1'b0;
      flag_clr = 3'b001;
      rx_load(pack(93, 4, 3));
      flag_clr = 3'b000;
      chk("R10 set wins clear", 32'(flags[0]), 32'h1);
      #1;
      flag_mask = 3'b110;
      #1;
      chk("R11 other masks", 32'(irq_n), 32'h1);
      flag_mask = 3'b001;
      #1;
      chk("R11 own mask", 32'(irq_n), 32'h0);
      flag_mask = 3'b000;

      // R8: lost cycle start
      clear_flags();
      rx_load(pack(93, 4, OM - 1));
      tick = 1'b1;
      wait_n(1);
      tick = 1'b0;
      chk("R2 wrap into seconds", ctime, pack(94, 0, 0));
      chk("R2 cyc_out non-master", 32'(cyc_out), 32'h1);
      chk("R6 no tx when not master", 32'(cs_tx_req), 32'h0);
      wait_n(LW);
      chk("R8 lost not yet", 32'(flags[1]), 32'h0);
      wait_n(1);
      chk("R8 lost at window end", 32'(flags[1]), 32'h1);
      clear_flags();
      rx_load(pack(94, 0, OM - 1));
      tick = 1'b1;
      wait_n(1);
      tick = 1'b0;
      wait_n(3);
      rx_load(pack(94, 1, 0));
      wait_n(LW + 3);
      chk("R8 start in window", 32'(flags[1]), 32'h0);

      // R9: cycle done
      gap_pulse();
      clear_flags();
      gap_pulse();
      wait_n(1);
      chk("R9 gap without start", 32'(flags[2]), 32'h0);
      rx_load(pack(94, 1, 0));
      gap_pulse();
      chk("R9 done after start", 32'(flags[2]), 32'h1);
      flag_mask = 3'b100;
      #1;
      chk("R11 done irq", 32'(irq_n), 32'h0);
      flag_mask = 3'b000;
      clear_flags();
      gap_pulse();
      wait_n(1);
      chk("R9 done once per cycle", 32'(flags[2]), 32'h0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule